// File: doc/BRIEF.md
# Byte-Serial Key Register with DoubleSwap

This block holds the 128-bit intermediate key of a Feistel-cipher key schedule and hands out round-key material one byte per clock. The byte presented at the output is always the leading (most significant) byte of the register, XORed with a constant byte that an external generator supplies in the same cycle. A rotate command moves that leading byte to the tail, so sixteen rotations walk the whole key past the output and bring the register back to where it started.

A 3-bit operation code selects one action per clock: hold, serial load, byte rotate, rotate followed by the DoubleSwap permutation, the half swap alone, the full DoubleSwap alone, the final swap, or a self-running recovery sequence. The DoubleSwap is built from two self-inverse bit permutations: a half swap followed by a sub-swap that moves two 57-bit fields and keeps the middle 14 bits in place. The recovery sequence undoes eight DoubleSwaps without any inverse-permutation hardware. It conjugates eight forward DoubleSwaps with two half swaps, and each half swap is made of eight byte rotations. While it runs, a busy flag is high and the operation code is ignored. Sequencing, the constant generator and the data path sit outside.

Top module: `keysched_lreg`

## Requirements
- R1: After reset the key register is all zeros and busy_o is low, so rk_byte_o equals const_byte_i.
- R2: rk_byte_o is combinationally the register's leading byte (vector bits 127:120, key bit positions 0 to 7 counted from the MSB) XORed with const_byte_i.
- R3: Operation code 1 (load) shifts the register left by one byte and places load_byte_i in the tail byte (bits 7:0); sixteen loads leave the first loaded byte leading.
- R4: Operation code 2 (rotate) moves the leading byte to the tail and every other byte up by one position.
- R5: Operation code 0 (hold) leaves the register unchanged.
- R6: Operation code 4 exchanges the 64-bit halves; operation code 5 applies DoubleSwap, which is the half swap followed by the sub-swap. Counting key bit positions from the MSB, the sub-swap output is positions 71..127, then 57..70, then 0..56.
- R7: Operation code 3 rotates by one byte and then applies DoubleSwap to the rotated value, in a single cycle.
- R8: Operation code 6 applies the final swap. Its output, counting key positions from the MSB, is the eight 7-bit fields starting at 49, 42, 35, 28, 21, 14, 7 and 0, then the byte at 64, the byte at 56, then the eight 7-bit fields starting at 121, 114, 107, 100, 93, 86, 79 and 72. Applying it twice restores the key.
- R9: Operation code 7 issued while idle raises busy_o from the next cycle for exactly 24 cycles (8 rotations, 8 DoubleSwaps, 8 rotations). When busy_o falls, the register holds the inverse of eight DoubleSwaps applied to the key at the start.
- R10: While busy_o is high, every operation code is ignored, including a repeated code 7, which neither restarts nor lengthens the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 hold, 1 load, 2 rotate, 3 rotate+DoubleSwap, 4 half swap, 5 DoubleSwap, 6 final swap, 7 recover) |
| load_byte_i | input | 8 | Byte shifted into the tail on load |
| const_byte_i | input | 8 | Constant byte XORed onto the round-key output |
| rk_byte_o | output | 8 | Leading key byte XOR constant byte |
| busy_o | output | 1 | High while the recovery sequence runs |

## Verification
The bench reads the whole key back through sixteen rotations. This catches a bit-order slip in either permutation, which would show up as a scrambled key and not as a wrong byte. Recovery is run both after eight real DoubleSwaps, where it must return the original key, and on an arbitrary key against an inverse built from the two involutions. A design that ran the phases in the wrong order, or miscounted any phase, would leave a different key. The busy window is counted while load and recover codes are driven into it. A design that restarted on a repeated recover would stretch busy past 24 cycles, and one that obeyed a load would corrupt the result. The final swap is checked once against its field map and again after a second application, which must restore the starting key.

// File: rtl/keysched_lreg_pkg.sv
package keysched_lreg_pkg;

   localparam int KEY_BITS = 128;
   localparam int OP_W     = 3;

   typedef enum logic [OP_W-1:0] {
      OP_HOLD    = 3'd0,
      OP_LOAD    = 3'd1,
      OP_ROT     = 3'd2,
      OP_ROTSIG  = 3'd3,
      OP_OMEGA   = 3'd4,
      OP_SIGMA   = 3'd5,
      OP_FINAL   = 3'd6,
      OP_RECOVER = 3'd7
   } lreg_op_e;

   typedef enum logic [1:0] {
      STEP_NONE  = 2'd0,
      STEP_ROT   = 2'd1,
      STEP_SIGMA = 2'd2,
      STEP_OMEGA = 2'd3
   } rec_step_e;

   typedef struct packed {
      logic [KEY_BITS-1:0] load;
      logic [KEY_BITS-1:0] rot;
      logic [KEY_BITS-1:0] rotsig;
      logic [KEY_BITS-1:0] omega;
      logic [KEY_BITS-1:0] sigma;
      logic [KEY_BITS-1:0] fin;
   } lreg_cand_t;

endpackage

// File: rtl/keysched_lreg_perm.sv
module keysched_lreg_perm
   import keysched_lreg_pkg::*;
#(
   parameter int KEY_W  = 128,
   parameter int LANE_W = 8
) (
   input  logic [KEY_W-1:0]  key_i,
   input  logic [LANE_W-1:0] load_i,
   output lreg_cand_t        cand_o
);

   localparam int HALF    = KEY_W / 2;
   localparam int PSI_LO  = 57;
   localparam int PSI_MID = 14;
   localparam int PSI_TOP = PSI_LO + PSI_MID;

   // leading lane goes to the tail
   function automatic logic [KEY_W-1:0] f_rot(input logic [KEY_W-1:0] x);
      return {x[KEY_W-LANE_W-1:0], x[KEY_W-1 -: LANE_W]};
   endfunction

   function automatic logic [KEY_W-1:0] f_omega(input logic [KEY_W-1:0] x);
      return {x[HALF-1:0], x[KEY_W-1:HALF]};
   endfunction

   // sub-swap: outer 57-bit fields trade places, middle 14 bits stay
   function automatic logic [KEY_W-1:0] f_psi(input logic [KEY_W-1:0] x);
      return {x[PSI_LO-1:0], x[PSI_TOP-1:PSI_LO], x[KEY_W-1:PSI_TOP]};
   endfunction

   function automatic logic [KEY_W-1:0] f_sigma(input logic [KEY_W-1:0] x);
      return f_psi(f_omega(x));
   endfunction

   // final swap, written as vector slices (vector bit = 127 - key position)
   function automatic logic [KEY_W-1:0] f_final(input logic [KEY_W-1:0] x);
      return {x[78:72],   x[85:79],   x[92:86],   x[99:93],
              x[106:100], x[113:107], x[120:114], x[127:121],
              x[63:56],   x[71:64],
              x[6:0],     x[13:7],    x[20:14],   x[27:21],
              x[34:28],   x[41:35],   x[48:42],   x[55:49]};
   endfunction

   logic [KEY_W-1:0] rot_w;

   assign rot_w         = f_rot(key_i);
   assign cand_o.rot    = rot_w;
   assign cand_o.load   = {key_i[KEY_W-LANE_W-1:0], load_i};
   assign cand_o.rotsig = f_sigma(rot_w);
   assign cand_o.omega  = f_omega(key_i);
   assign cand_o.sigma  = f_sigma(key_i);
   assign cand_o.fin    = f_final(key_i);

endmodule

// File: rtl/keysched_lreg_seq.sv
module keysched_lreg_seq
   import keysched_lreg_pkg::*;
#(
   parameter int HALF_ROTS   = 8,
   parameter int UNDO_SIGMAS = 8,
   parameter int REC_STYLE   = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  lreg_op_e  op_i,
   output logic      busy_o,
   output rec_step_e step_o
);

   localparam int REC_LEN = (REC_STYLE == 0) ? (2 * HALF_ROTS + UNDO_SIGMAS)
                                              : (2 + UNDO_SIGMAS);
   localparam int CW      = $clog2(REC_LEN + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (op_i == OP_RECOVER) begin
         cnt_q <= CW'(REC_LEN);
      end
   end

   assign busy_o = (cnt_q != '0);
   assign idx    = CW'(REC_LEN) - cnt_q;

   generate
      if (REC_STYLE == 0) begin : g_rot_omega
         // half swap realised as a run of lane rotations
         always_comb begin
            if (!busy_o)                                  step_o = STEP_NONE;
            else if (idx < CW'(HALF_ROTS))                step_o = STEP_ROT;
            else if (idx < CW'(HALF_ROTS + UNDO_SIGMAS))  step_o = STEP_SIGMA;
            else                                          step_o = STEP_ROT;
         end
      end else begin : g_direct_omega
         // half swap in one cycle through the direct exchange
         always_comb begin
            if (!busy_o)                         step_o = STEP_NONE;
            else if (idx == '0)                  step_o = STEP_OMEGA;
            else if (idx <= CW'(UNDO_SIGMAS))    step_o = STEP_SIGMA;
            else                                 step_o = STEP_OMEGA;
         end
      end
   endgenerate

   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && op_i == OP_RECOVER) |=> busy_o);

   // a recover code during the run must not reload the counter
   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cnt_q != CW'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/keysched_lreg_store.sv
module keysched_lreg_store
   import keysched_lreg_pkg::*;
#(
   parameter int KEY_W  = 128,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lreg_op_e          op_i,
   input  logic              busy_i,
   input  rec_step_e         step_i,
   input  logic [LANE_W-1:0] load_i,
   input  lreg_cand_t        cand_i,
   output logic [KEY_W-1:0]  key_o
);

   logic [KEY_W-1:0] key_q;
   logic [KEY_W-1:0] nxt;
   logic             upd_en;

   always_comb begin
      nxt    = key_q;
      upd_en = 1'b1;
      if (busy_i) begin
         unique case (step_i)
            STEP_ROT:   nxt = cand_i.rot;
            STEP_SIGMA: nxt = cand_i.sigma;
            STEP_OMEGA: nxt = cand_i.omega;
            default:    upd_en = 1'b0;
         endcase
      end else begin
         unique case (op_i)
            OP_LOAD:   nxt = cand_i.load;
            OP_ROT:    nxt = cand_i.rot;
            OP_ROTSIG: nxt = cand_i.rotsig;
            OP_OMEGA:  nxt = cand_i.omega;
            OP_SIGMA:  nxt = cand_i.sigma;
            OP_FINAL:  nxt = cand_i.fin;
            default:   upd_en = 1'b0;
         endcase
      end
   end

   // enable-gated register: hold costs no feedback path when gated
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
      end else if (upd_en) begin
         key_q <= nxt;
      end
   end

   assign key_o = key_q;

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && op_i == OP_HOLD) |=> $stable(key_q));

   assert_load_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && op_i == OP_LOAD) |=> (key_q[LANE_W-1:0] == $past(load_i)));

   assert_rot_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && op_i == OP_ROT) |=> (key_q[LANE_W-1:0] == $past(key_q[KEY_W-1 -: LANE_W])));

   assert_final_twice_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && op_i == OP_FINAL) ##1 (!busy_i && op_i == OP_FINAL) |=> (key_q == $past(key_q, 2)));

endmodule

// File: rtl/keysched_lreg.sv
module keysched_lreg
   import keysched_lreg_pkg::*;
#(
   parameter int KEY_W       = 128,
   parameter int LANE_W      = 8,
   parameter int UNDO_SIGMAS = 8,
   parameter int REC_STYLE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_i,
   input  logic [LANE_W-1:0] load_byte_i,
   input  logic [LANE_W-1:0] const_byte_i,
   output logic [LANE_W-1:0] rk_byte_o,
   output logic              busy_o
);

   localparam int LANES     = KEY_W / LANE_W;
   localparam int HALF_ROTS = LANES / 2;

   generate
      if (KEY_W != KEY_BITS) begin : g_bad_key_w
         $error("keysched_lreg: the permutations are defined for a 128-bit key only");
      end
      if (((KEY_W / 2) % LANE_W) != 0) begin : g_bad_lane_w
         $error("keysched_lreg: LANE_W must divide half the key width");
      end
      if (REC_STYLE != 0 && REC_STYLE != 1) begin : g_bad_style
         $error("keysched_lreg: REC_STYLE must be 0 or 1");
      end
   endgenerate

   lreg_op_e         op;
   rec_step_e        step;
   lreg_cand_t       cand;
   logic [KEY_W-1:0] key;

   assign op = lreg_op_e'(op_i);

   keysched_lreg_perm #(.KEY_W(KEY_W), .LANE_W(LANE_W)) u_perm (
      .key_i  (key),
      .load_i (load_byte_i),
      .cand_o (cand)
   );

   keysched_lreg_seq #(
      .HALF_ROTS   (HALF_ROTS),
      .UNDO_SIGMAS (UNDO_SIGMAS),
      .REC_STYLE   (REC_STYLE)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (op),
      .busy_o (busy_o),
      .step_o (step)
   );

   keysched_lreg_store #(.KEY_W(KEY_W), .LANE_W(LANE_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (op),
      .busy_i (busy_o),
      .step_i (step),
      .load_i (load_byte_i),
      .cand_i (cand),
      .key_o  (key)
   );

   // R2: round-key byte straight from the leading lane
   assign rk_byte_o = key[KEY_W-1 -: LANE_W] ^ const_byte_i;

endmodule

// File: tb/tb_keysched_lreg.sv
module tb_keysched_lreg;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_i = 3'd0;
   logic [7:0] load_byte_i = 8'h00;
   logic [7:0] const_byte_i = 8'h00;
   logic [7:0] rk_byte_o;
   logic       busy_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   keysched_lreg dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_i         (op_i),
      .load_byte_i  (load_byte_i),
      .const_byte_i (const_byte_i),
      .rk_byte_o    (rk_byte_o),
      .busy_o       (busy_o)
   );

   // ---------------- reference model, key position p = vector bit 127-p
   function automatic logic [127:0] m_rot(input logic [127:0] x);
      logic [127:0] y;
      for (int p = 0; p < 128; p++) y[127-p] = x[127-((p+8)%128)];
      return y;
   endfunction

   function automatic logic [127:0] m_omega(input logic [127:0] x);
      logic [127:0] y;
      for (int p = 0; p < 128; p++) y[127-p] = x[127-((p+64)%128)];
      return y;
   endfunction

   function automatic logic [127:0] m_psi(input logic [127:0] x);
      logic [127:0] y;
      for (int p = 0; p < 128; p++) begin
         int s;
         if (p < 57)      s = p + 71;
         else if (p < 71) s = p;
         else             s = p - 71;
         y[127-p] = x[127-s];
      end
      return y;
   endfunction

   function automatic logic [127:0] m_sigma(input logic [127:0] x);
      return m_psi(m_omega(x));
   endfunction

   function automatic logic [127:0] m_sigma_inv(input logic [127:0] x);
      return m_omega(m_psi(x));
   endfunction

   function automatic logic [127:0] m_final(input logic [127:0] x);
      logic [127:0] y;
      int st[18];
      int ln[18];
      int pos;
      for (int j = 0; j < 8; j++) begin
         st[j] = 49 - 7*j;   ln[j] = 7;
         st[10+j] = 121 - 7*j; ln[10+j] = 7;
      end
      st[8] = 64; ln[8] = 8;
      st[9] = 56; ln[9] = 8;
      pos = 0;
      for (int c = 0; c < 18; c++) begin
         for (int b = 0; b < ln[c]; b++) begin
            y[127-pos] = x[127-(st[c]+b)];
            pos++;
         end
      end
      return y;
   endfunction

   // ---------------- checking helpers
   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic [7:0] lb);
      @(negedge clk);
      op_i = op;
      load_byte_i = lb;
      @(posedge clk);
   endtask

   task automatic load_key(input logic [127:0] k);
      for (int i = 0; i < 16; i++) apply(3'd1, k[127-8*i -: 8]);
   endtask

   // walks the key past the output with 16 rotations, leaving it unchanged
   task automatic read_key(output logic [127:0] k);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         op_i = 3'd2;
         const_byte_i = 8'h00;
         #1;
         k[127-8*i -: 8] = rk_byte_o;
         @(posedge clk);
      end
      @(negedge clk);
      op_i = 3'd0;
   endtask

   localparam logic [127:0] KA = 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff;
   localparam logic [127:0] KB = 128'hf0e1_d2c3_b4a5_9687_7869_5a4b_3c2d_1e0f;
   localparam logic [127:0] KC = 128'h8000_0000_0000_0001_0123_4567_89ab_cdef;

   // ---------------- scenarios
   task automatic t_reset();
      @(negedge clk);
      const_byte_i = 8'h5a;
      #1;
      chk("R1 rk after reset", {120'd0, rk_byte_o}, {120'd0, 8'h5a});
      chk("R1 busy after reset", {127'd0, busy_o}, 128'd0);
   endtask

   task automatic t_load_rot();
      logic [127:0] k;
      load_key(KA);
      read_key(k);
      chk("R3 sixteen loads", k, KA);
      apply(3'd1, 8'hab);
      read_key(k);
      chk("R3 single load shift", k, {KA[119:0], 8'hab});
      apply(3'd2, 8'h00);
      read_key(k);
      chk("R4 one rotation", k, m_rot({KA[119:0], 8'hab}));
   endtask

   task automatic t_rk_const();
      load_key(KB);
      @(negedge clk);
      op_i = 3'd0;
      const_byte_i = 8'h3c;
      #1;
      chk("R2 rk xor const 3c", {120'd0, rk_byte_o}, {120'd0, KB[127:120] ^ 8'h3c});
      const_byte_i = 8'hff;
      #1;
      chk("R2 rk xor const ff", {120'd0, rk_byte_o}, {120'd0, KB[127:120] ^ 8'hff});
   endtask

   task automatic t_hold();
      logic [127:0] k;
      load_key(KC);
      for (int i = 0; i < 5; i++) apply(3'd0, 8'h77);
      read_key(k);
      chk("R5 hold keeps key", k, KC);
   endtask

   task automatic t_omega_sigma();
      logic [127:0] k;
      load_key(KA);
      apply(3'd4, 8'h00);
      read_key(k);
      chk("R6 half swap", k, m_omega(KA));
      load_key(KB);
      apply(3'd5, 8'h00);
      read_key(k);
      chk("R6 doubleswap", k, m_sigma(KB));
   endtask

   task automatic t_rotsig();
      logic [127:0] k;
      load_key(KC);
      apply(3'd3, 8'h00);
      read_key(k);
      chk("R7 rotate then doubleswap", k, m_sigma(m_rot(KC)));
   endtask

   task automatic t_final();
      logic [127:0] k;
      load_key(KB);
      apply(3'd6, 8'h00);
      read_key(k);
      chk("R8 final swap", k, m_final(KB));
      apply(3'd6, 8'h00);
      apply(3'd6, 8'h00);
      read_key(k);
      chk("R8 final swap twice", k, m_final(KB));
   endtask

   // runs recovery while driving junk codes, returns busy length
   task automatic run_recover(output int len);
      logic done;
      apply(3'd7, 8'h00);
      len = 0;
      done = 1'b0;
      for (int c = 0; c < 40; c++) begin
         if (!done) begin
            @(negedge clk);
            if (busy_o) begin
               len++;
               op_i = (c % 2 == 0) ? 3'd1 : 3'd7;
               load_byte_i = 8'hee;
            end else begin
               op_i = 3'd0;
               done = 1'b1;
            end
         end
      end
   endtask

   task automatic t_recover();
      logic [127:0] k;
      logic [127:0] exp;
      int len;
      load_key(KA);
      for (int i = 0; i < 8; i++) apply(3'd5, 8'h00);
      exp = KA;
      for (int i = 0; i < 8; i++) exp = m_sigma(exp);
      read_key(k);
      chk("R6 eight doubleswaps", k, exp);
      run_recover(len);
      chk("R9 busy length", 128'(len), 128'd24);
      read_key(k);
      chk("R9 R10 recovered key", k, KA);
      load_key(KC);
      run_recover(len);
      chk("R10 busy not stretched", 128'(len), 128'd24);
      exp = KC;
      for (int i = 0; i < 8; i++) exp = m_sigma_inv(exp);
      read_key(k);
      chk("R9 inverse of eight doubleswaps", k, exp);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_rot();
      t_rk_const();
      t_hold();
      t_omega_sigma();
      t_rotsig();
      t_final();
      t_recover();
      finish_run();
   end

endmodule